// File: doc/BRIEF.md
# MII Transmit Nibble Framer

This block takes an outgoing frame as a stream of bytes and turns it into the 4-bit nibble stream of a media independent interface transmitter, one nibble per transmit clock. A frame begins when the byte source raises `in_valid` while the line is idle. The block first sends the preamble nibbles and the start-of-frame delimiter, and then sends the payload bytes with the low nibble first. A payload shorter than the minimum is extended with zero bytes. The frame ends with a 32-bit frame check sequence.

Bytes pass through a valid/ready handshake. `in_ready` is high for exactly one clock per byte. That clock is the delimiter nibble for the first byte, and the high-nibble slot of the byte now on the line for each byte after it. The block therefore holds only one byte. The source marks the final byte with `in_last`. It can flag a damaged byte with `in_err`, which the block reflects on `tx_er` for both nibbles of that byte. If the source has no byte ready in an accept slot, the payload ends there and the frame is closed cleanly. After every frame the line stays idle for an enforced gap.

Top module: `mii_tx_framer`

## Requirements
- R1: After reset, and at all times between frames, `tx_en`, `tx_er` and `in_ready` are low and `txd` is 0. Within a frame, `tx_en` stays high without a break from the first preamble nibble to the last check-sequence nibble.
- R2: Nibble positions 0 to 14 of every frame carry 0x5.
- R3: Nibble position 15 carries 0xD.
- R4: From position 16 on, each byte goes out as two nibbles: bits 3:0 first, then bits 7:4.
- R5: A frame whose payload has N bytes has exactly 16 + 2*max(N,60) + 8 nibbles, so the count after the delimiter is always even.
- R6: `tx_er` is high on exactly the two nibbles of a byte that was accepted with `in_err` high, and is low on every other nibble.
- R7: The last 8 nibbles hold the inverted CRC-32, least significant nibble first. The CRC is the reflected form with polynomial 0xEDB88320, starts from all ones, and covers the payload plus any padding. Running the same CRC over the received bytes and the check sequence leaves the residue 0xDEBB20E3.
- R8: A payload shorter than 60 bytes is followed by zero bytes up to 60 bytes before the check sequence.
- R9: Between consecutive frames, `tx_en` is low for at least 24 clocks.
- R10: `in_ready` is high only at nibble position 15 and at the high-nibble slot of a byte not marked last. It is never high for two clocks in a row.
- R11: If `in_valid` is low in an accept slot, the payload ends with the bytes already taken. The frame is padded and closed as in R5 to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit nibble clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Byte available; raising it while idle starts a frame |
| in_last | input | 1 | Marks the final payload byte |
| in_err | input | 1 | Marks the byte as corrupted |
| in_ready | output | 1 | Byte taken at this clock edge when `in_valid` is high |
| txd | output | 4 | Transmit nibble |
| tx_en | output | 1 | Transmit enable, high for the whole frame |
| tx_er | output | 1 | Transmit error for the current byte |

## Verification
The bench sends payloads of 4, 59, 60 and 70 bytes, which cover the padding boundary from both sides. A padding counter that is off by one would give a nibble count that is wrong by two, and it would also break the CRC residue. One test flags a single byte mid-payload with `in_err`. This catches a `tx_er` that lands on the neighbouring byte or lasts only one nibble. Another test stops supplying bytes without setting `in_last`; a design that stalls or sends a dribble nibble at that point is exposed. Two frames sent back to back check the idle gap, and the exact positions of `in_ready` within each frame are compared, so a block that takes a byte in the wrong slot or takes two bytes per slot is reported.

// File: rtl/mii_tx_framer.sv
module mii_tx_framer #(
  parameter int MIN_PAYLOAD = 60,
  parameter int GAP_NIBBLES = 24,
  parameter int PRE_NIBBLES = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  input  logic       in_err,
  output logic       in_ready,
  output logic [3:0] txd,
  output logic       tx_en,
  output logic       tx_er
);
  localparam int CMAX = (GAP_NIBBLES > PRE_NIBBLES) ? GAP_NIBBLES : PRE_NIBBLES;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int NBW  = $clog2(MIN_PAYLOAD + 1);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_SFD, S_DATA, S_PAD, S_FCS, S_GAP} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic           half;
  logic [7:0]     byte_q;
  logic           err_q, last_q;
  logic [NBW-1:0] nbytes;
  logic [31:0]    crc;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  logic [7:0]  cur_byte;
  logic [31:0] crc_nx, fcs;
  logic        take, short_pl;
  logic [NBW-1:0] nbytes_inc;

  assign cur_byte   = (st == S_DATA) ? byte_q : 8'h00;
  assign crc_nx     = crc_byte(crc, cur_byte);
  assign fcs        = ~crc;
  assign in_ready   = (st == S_SFD) || (st == S_DATA && half && !last_q);
  assign take       = in_ready && in_valid;
  assign short_pl   = (int'(nbytes) + 1) < MIN_PAYLOAD;
  assign nbytes_inc = (int'(nbytes) >= MIN_PAYLOAD) ? nbytes : nbytes + NBW'(1);
  assign tx_en      = (st != S_IDLE) && (st != S_GAP);
  assign tx_er      = (st == S_DATA) && err_q;

  always_comb begin
    case (st)
      S_PRE:          txd = 4'h5;
      S_SFD:          txd = 4'hD;
      S_DATA, S_PAD:  txd = half ? cur_byte[7:4] : cur_byte[3:0];
      S_FCS:          txd = fcs[{cnt[2:0], 2'b00} +: 4];
      default:        txd = 4'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      half   <= 1'b0;
      byte_q <= 8'h00;
      err_q  <= 1'b0;
      last_q <= 1'b0;
      nbytes <= '0;
      crc    <= 32'hFFFF_FFFF;
    end else begin
      if (take) begin
        byte_q <= in_data;
        err_q  <= in_err;
        last_q <= in_last;
      end
      case (st)
        S_IDLE: if (in_valid) begin
          st     <= S_PRE;
          cnt    <= '0;
          nbytes <= '0;
          crc    <= 32'hFFFF_FFFF;
        end
        S_PRE: begin
          if (cnt == CW'(PRE_NIBBLES - 1)) st <= S_SFD;
          else cnt <= cnt + CW'(1);
        end
        S_SFD: begin
          half <= 1'b0;
          st   <= take ? S_DATA : S_PAD;
        end
        S_DATA, S_PAD: begin
          if (!half) half <= 1'b1;
          else begin
            half   <= 1'b0;
            crc    <= crc_nx;
            nbytes <= nbytes_inc;
            if (take) st <= S_DATA;
            else if (short_pl) st <= S_PAD;
            else begin
              st  <= S_FCS;
              cnt <= '0;
            end
          end
        end
        S_FCS: begin
          if (cnt == CW'(7)) begin
            st  <= S_GAP;
            cnt <= '0;
          end else cnt <= cnt + CW'(1);
        end
        S_GAP: begin
          if (cnt == CW'(GAP_NIBBLES - 1)) st <= S_IDLE;
          else cnt <= cnt + CW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module mii_tx_framer_chk #(
  parameter int GAP_NIBBLES = 24
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic [3:0] txd,
  input logic       tx_en,
  input logic       tx_er
);
  logic [15:0] lowcnt;
  logic        seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lowcnt <= '0;
      seen   <= 1'b0;
    end else if (tx_en) begin
      lowcnt <= '0;
      seen   <= 1'b1;
    end else if (lowcnt != 16'hFFFF) begin
      lowcnt <= lowcnt + 16'd1;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> (txd == 4'h0 && !tx_er && !in_ready));

  assert_first_nibble_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> txd == 4'h5);

  assert_er_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_er |-> tx_en);

  assert_min_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_en) && seen) |-> lowcnt >= 16'(GAP_NIBBLES));

  assert_single_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> (!in_ready && tx_en));
endmodule

bind mii_tx_framer mii_tx_framer_chk #(.GAP_NIBBLES(GAP_NIBBLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .txd(txd), .tx_en(tx_en), .tx_er(tx_er)
);

// File: tb/mii_tx_framer_bench.sv
module mii_tx_framer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0, in_last = 1'b0, in_err = 1'b0;
  logic       in_ready, tx_en, tx_er;
  logic [3:0] txd;

  mii_tx_framer u_mii_tx_framer (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_err(in_err), .in_ready(in_ready),
    .txd(txd), .tx_en(tx_en), .tx_er(tx_er)
  );

  always #5 clk = ~clk;

  int total = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] pay [0:127];
  logic [3:0] nib [0:2047];
  bit er_a [0:2047];
  bit rdy_a [0:2047];
  int ncap;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_step(logic [31:0] c, logic [7:0] d);
    for (int i = 0; i < 8; i++)
      c = (c[0] ^ d[i]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    return c;
  endfunction

  task automatic fill(int seed);
    for (int i = 0; i < 128; i++) pay[i] = 8'((i * 37 + seed) ^ (i >> 2));
  endtask

  task automatic drive(int n, bit mark_last, int erridx);
    for (int i = 0; i < n; i++) begin
      in_data  = pay[i];
      in_valid = 1'b1;
      in_last  = mark_last && (i == n - 1);
      in_err   = (i == erridx);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1;
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    in_err   = 1'b0;
  endtask

  task automatic capture(bit started);
    ncap = 0;
    if (!started) begin
      @(negedge clk);
      while (!tx_en) @(negedge clk);
    end
    while (tx_en && ncap < 2048) begin
      nib[ncap] = txd;
      er_a[ncap] = tx_er;
      rdy_a[ncap] = in_ready;
      ncap++;
      @(negedge clk);
    end
    chk(!tx_en && txd == 4'h0 && !tx_er, "R1", "line quiet after frame", txd, 0);
  endtask

  task automatic check_frame(string tag, int n, int erridx, bit ready_last);
    int body, exp_len, bad, first, k;
    logic [31:0] c;
    logic [7:0] b;
    body = (n < 60) ? 60 : n;
    exp_len = 16 + 2 * body + 8;
    chk(ncap == exp_len, "R5", {tag, " nibble count"}, ncap, exp_len);
    if (ncap != exp_len) return;
    bad = 0;
    for (int i = 0; i < 15; i++) if (nib[i] != 4'h5) bad++;
    chk(bad == 0, "R2", {tag, " preamble nibbles wrong"}, bad, 0);
    chk(nib[15] == 4'hD, "R3", {tag, " delimiter"}, nib[15], 4'hD);
    bad = 0; first = -1;
    for (int i = 0; i < n; i++)
      if (nib[16 + 2*i] != pay[i][3:0] || nib[17 + 2*i] != pay[i][7:4]) begin
        bad++;
        if (first < 0) first = i;
      end
    chk(bad == 0, "R4", {tag, " payload bytes wrong, first index"}, first, -1);
    bad = 0;
    for (int i = n; i < body; i++)
      if (nib[16 + 2*i] != 4'h0 || nib[17 + 2*i] != 4'h0) bad++;
    chk(bad == 0, "R8", {tag, " nonzero pad bytes"}, bad, 0);
    bad = 0;
    for (int i = 0; i < ncap; i++) begin
      bit e;
      e = (i >= 16) && (erridx >= 0) && (erridx < n) && ((i - 16) / 2 == erridx);
      if (er_a[i] != e) bad++;
    end
    chk(bad == 0, "R6", {tag, " tx_er mismatches"}, bad, 0);
    bad = 0;
    for (int i = 0; i < ncap; i++) begin
      bit r;
      k = (i - 17) / 2;
      r = (i == 15) || (i >= 17 && (i % 2 == 1) && (k < n - 1 || (ready_last && k == n - 1)));
      if (rdy_a[i] != r) bad++;
    end
    chk(bad == 0, "R10", {tag, " in_ready slot mismatches"}, bad, 0);
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < body + 4; i++) begin
      b = {nib[17 + 2*i], nib[16 + 2*i]};
      c = crc_step(c, b);
    end
    chk(c == 32'hDEBB20E3, "R7", {tag, " CRC residue"}, c, 32'hDEBB20E3);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!tx_en && !tx_er && !in_ready && txd == 4'h0, "R1", "reset outputs",
        {tx_en, tx_er, in_ready, txd}, 0);
  endtask

  task automatic t_frame(string tag, int n, int erridx, int seed);
    fill(seed);
    fork
      drive(n, 1'b1, erridx);
      capture(1'b0);
    join
    check_frame(tag, n, erridx, 1'b0);
  endtask

  task automatic t_underrun_R11;
    fill(91);
    fork
      drive(3, 1'b0, -1);
      capture(1'b0);
    join
    check_frame("R11 underrun", 3, -1, 1'b1);
  endtask

  task automatic t_back_to_back_R9;
    int gap;
    fill(5);
    fork
      begin
        drive(8, 1'b1, -1);
        drive(5, 1'b1, -1);
      end
      begin
        capture(1'b0);
        check_frame("b2b first", 8, -1, 1'b0);
        gap = 1;
        @(negedge clk);
        while (!tx_en && gap < 1000) begin
          gap++;
          @(negedge clk);
        end
        chk(gap >= 24, "R9", "idle gap between frames", gap, 24);
        capture(1'b1);
        check_frame("b2b second", 5, -1, 1'b0);
      end
    join
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_frame("short4", 4, -1, 17);
    t_frame("long70 err10", 70, 10, 33);
    t_frame("exact60", 60, -1, 71);
    t_frame("pad59 err58", 59, 58, 2);
    t_underrun_R11();
    t_back_to_back_R9();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule